// File: doc/BRIEF.md
# Tile Row Fetch Address Generator

This block serves one pixel row of one tile in a three-third bitmap graphics mode. It takes the screen third, the 8-bit tile name and the 3-bit row within the tile, together with two table registers. From these it forms two 14-bit video memory addresses, one for the pattern byte and one for the colour byte. The register bits are not only base pointers. They also act as AND masks on the third and on the upper tile-name bits, so a small table makes several tiles share the same bytes. The pattern address takes its tile-name mask from the low five bits of the colour register. For this reason, a colour table smaller than 2 KB also reduces the number of distinct patterns.

A row request is accepted with a valid/ready handshake. The block then issues the pattern read and after it the colour read, each through a valid/ready request channel. Each response comes back one or more cycles after its request is accepted. When both bytes are in, the block raises a one-cycle done pulse and presents eight 4-bit pixel colour indices. Name-table fetching, sprites, the memory itself and video timing belong to other blocks.

Top module: `tile_row_fetch`

## Requirements
- R1: While reset is held and after it is released, `start_ready` is 1, `mem_req_valid` is 0 and `row_done` is 0.
- R2: After a row is accepted, the block issues exactly two memory requests: first the pattern address, then the colour address. While `mem_req_ready` is 0, `mem_req_valid` stays 1 and `mem_req_addr` does not change.
- R3: Colour address bit 13 equals colour register bit 7. Bits 12:6 equal colour register bits 6:0 ANDed with {third[1:0], name[7:3]}. Bits 5:3 are name[2:0] and bits 2:0 are the row.
- R4: Pattern address bit 13 equals pattern register bit 2. Bits 12:11 equal pattern register bits 1:0 ANDed with the third. Bits 10:6 equal colour register bits 4:0 ANDed with name[7:3]. Bits 5:0 are {name[2:0], row}.
- R5: A colour register of 0x00 gives colour address 8*(name mod 8)+row. A value of 0x80 gives 0x2000 plus that offset. In both cases names that are equal mod 8 share one 8-byte group in every third.
- R6: A colour register of 0x9F gives colour address 0x2000+8*name+row, whatever the third.
- R7: When colour register bits 4:0 are zero, the pattern address is 0x2000*p[2] + 0x800*(p[1:0] AND third) + 8*(name mod 8) + row, where p is the pattern register. Small colour tables therefore reduce the number of distinct patterns.
- R8: Pixel i (0 = leftmost) sits in `row_pixels[4i+3:4i]`. It is colour byte bits 7:4 when pattern bit 7-i is 1, and colour byte bits 3:0 otherwise.
- R9: `row_done` is high for exactly one cycle. It rises in the cycle after the colour response is taken. `start_ready` is 0 from row acceptance until `row_done` has been shown, so a `start_valid` seen in that time is not taken.
- R10: A `mem_rsp_valid` while no read is outstanding is ignored. No done pulse and no request follow from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Row request valid |
| start_ready | output | 1 | Block idle, row request taken when valid |
| start_third | input | 2 | Screen third, 0 to 2 |
| start_name | input | 8 | Tile name from the name table |
| start_line | input | 3 | Pixel row within the tile |
| col_reg | input | 8 | Colour table register: bit 7 base, bits 6:0 mask |
| pat_reg | input | 3 | Pattern table register: bit 2 base, bits 1:0 third mask |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 14 | Memory read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Read data byte |
| row_done | output | 1 | One-cycle pulse, pixels valid |
| row_pixels | output | 32 | Eight 4-bit colour indices, pixel 0 in bits 3:0 |

## Verification
If the sequencer state is wrong, the result shows at the ports within one or two cycles. It appears as a request issued out of order, an address that changes under back-pressure, a done pulse without a colour response, or `start_ready` rising while a read is still outstanding. If the captured name, row or register value is wrong, the very next request address is wrong, and that shows before any data returns. If the pattern and colour bytes are latched in the wrong order, the pixel vector is wrong in the done cycle itself. The sweep covers every tile name in every third under four colour-register values with varied stalls, so every mask bit is exercised at least once.

// File: rtl/tf_pkg.sv
// Shared types for the tile row fetch block.
// Assumes a single outstanding read at a time, with in-order responses.
package tf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PAT_REQ  = 3'd1,
        ST_PAT_WAIT = 3'd2,
        ST_COL_REQ  = 3'd3,
        ST_COL_WAIT = 3'd4,
        ST_DONE     = 3'd5
    } tf_state_t;
endpackage

// File: rtl/tf_addr_gen.sv
// Forms the pattern and colour addresses of one tile row.
// The register bits act as AND masks on the third and on the upper name bits.
// The pattern address reuses the low colour-register mask bits for the name.
// Purely combinational.
module tf_addr_gen #(
    parameter int THIRD_W = 2,
    parameter int NAME_W  = 8,
    parameter int LINE_W  = 3,
    localparam int HI_W    = NAME_W - LINE_W,
    localparam int CMASK_W = THIRD_W + HI_W,
    localparam int LO_W    = 2 * LINE_W,
    localparam int ADDR_W  = 1 + CMASK_W + LO_W
) (
    input  logic [THIRD_W-1:0] third,
    input  logic [NAME_W-1:0]  name,
    input  logic [LINE_W-1:0]  line,
    input  logic [CMASK_W:0]   col_reg,
    input  logic [THIRD_W:0]   pat_reg,
    output logic [ADDR_W-1:0]  pat_addr,
    output logic [ADDR_W-1:0]  col_addr
);
    logic [LO_W-1:0]    low_part;
    logic [CMASK_W-1:0] col_mid;
    logic [THIRD_W-1:0] pat_third;
    logic [HI_W-1:0]    pat_name;

    // Row offset inside the 64-byte group: low name bits, then the row
    assign low_part = {name[LINE_W-1:0], line};

    // Colour mask covers the third and the upper name bits together
    assign col_mid = col_reg[CMASK_W-1:0] & {third, name[NAME_W-1:LINE_W]};

    // Pattern third mask comes from the pattern register alone
    assign pat_third = pat_reg[THIRD_W-1:0] & third;

    // Pattern name mask borrows the low colour-register bits
    assign pat_name = col_reg[HI_W-1:0] & name[NAME_W-1:LINE_W];

    // Assemble both addresses
    always_comb begin
        col_addr = {col_reg[CMASK_W], col_mid, low_part};
        pat_addr = {pat_reg[THIRD_W], pat_third, pat_name, low_part};
    end
endmodule

// File: rtl/tf_fetch_seq.sv
// Sequences the pattern read and then the colour read for one row.
// Holds each request until it is accepted, then waits for its response.
// Latches both returned bytes and pulses done for one cycle.
// Assumes that responses come back in order and never in the cycle of acceptance.
module tf_fetch_seq #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    output logic              accept,
    input  logic [ADDR_W-1:0] pat_addr,
    input  logic [ADDR_W-1:0] col_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic [DATA_W-1:0] pat_byte,
    output logic [DATA_W-1:0] col_byte,
    output logic              done
);
    import tf_pkg::*;

    tf_state_t state_q, state_d;

    // Handshake and request outputs, decoded from the state
    always_comb begin
        start_ready   = (state_q == ST_IDLE);
        accept        = start_ready && start_valid;
        mem_req_valid = (state_q == ST_PAT_REQ) || (state_q == ST_COL_REQ);
        mem_req_addr  = (state_q == ST_COL_REQ) ? col_addr : pat_addr;
        done          = (state_q == ST_DONE);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (start_valid)   state_d = ST_PAT_REQ;
            ST_PAT_REQ:  if (mem_req_ready) state_d = ST_PAT_WAIT;
            ST_PAT_WAIT: if (mem_rsp_valid) state_d = ST_COL_REQ;
            ST_COL_REQ:  if (mem_req_ready) state_d = ST_COL_WAIT;
            ST_COL_WAIT: if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:                        state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the returned bytes in the matching wait state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_byte <= '0;
            col_byte <= '0;
        end else begin
            if (state_q == ST_PAT_WAIT && mem_rsp_valid) pat_byte <= mem_rsp_data;
            if (state_q == ST_COL_WAIT && mem_rsp_valid) col_byte <= mem_rsp_data;
        end
    end
endmodule

// File: rtl/tf_pixel_expand.sv
// Turns one pattern byte and one colour byte into per-pixel colour indices.
// Pattern bit 1 selects the upper colour nibble, bit 0 the lower one.
// The most significant pattern bit is the leftmost pixel, which is placed in slot 0.
module tf_pixel_expand #(
    parameter int NUM_PIX = 8,
    parameter int COLOR_W = 4
) (
    input  logic [NUM_PIX-1:0]         pat_byte,
    input  logic [2*COLOR_W-1:0]       col_byte,
    output logic [NUM_PIX*COLOR_W-1:0] pixels
);
    logic [COLOR_W-1:0] fg;
    logic [COLOR_W-1:0] bg;

    // Split the colour byte into its foreground and background halves
    assign fg = col_byte[2*COLOR_W-1:COLOR_W];
    assign bg = col_byte[COLOR_W-1:0];

    // One selector per pixel
    for (genvar i = 0; i < NUM_PIX; i++) begin : g_pix
        assign pixels[i*COLOR_W +: COLOR_W] = pat_byte[NUM_PIX-1-i] ? fg : bg;
    end
endmodule

// File: rtl/tile_row_fetch.sv
// Top of the tile row fetch block.
// Captures one row request, has the addresses formed, runs the two reads
// and presents the pixel colours with a done pulse.
// Assumes that the register inputs are sampled only when a request is accepted.
module tile_row_fetch #(
    parameter int THIRD_W = 2,
    parameter int NAME_W  = 8,
    parameter int LINE_W  = 3,
    parameter int COLOR_W = 4,
    localparam int HI_W    = NAME_W - LINE_W,
    localparam int CMASK_W = THIRD_W + HI_W,
    localparam int ADDR_W  = 1 + CMASK_W + 2 * LINE_W,
    localparam int NUM_PIX = 1 << LINE_W,
    localparam int DATA_W  = 2 * COLOR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_valid,
    output logic                       start_ready,
    input  logic [THIRD_W-1:0]         start_third,
    input  logic [NAME_W-1:0]          start_name,
    input  logic [LINE_W-1:0]          start_line,
    input  logic [CMASK_W:0]           col_reg,
    input  logic [THIRD_W:0]           pat_reg,
    output logic                       mem_req_valid,
    input  logic                       mem_req_ready,
    output logic [ADDR_W-1:0]          mem_req_addr,
    input  logic                       mem_rsp_valid,
    input  logic [DATA_W-1:0]          mem_rsp_data,
    output logic                       row_done,
    output logic [NUM_PIX*COLOR_W-1:0] row_pixels
);
    logic               accept;
    logic [THIRD_W-1:0] third_q;
    logic [NAME_W-1:0]  name_q;
    logic [LINE_W-1:0]  line_q;
    logic [CMASK_W:0]   col_reg_q;
    logic [THIRD_W:0]   pat_reg_q;
    logic [ADDR_W-1:0]  pat_addr;
    logic [ADDR_W-1:0]  col_addr;
    logic [NUM_PIX-1:0] pat_byte;
    logic [DATA_W-1:0]  col_byte;

    // Hold the request fields for the whole row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            third_q   <= '0;
            name_q    <= '0;
            line_q    <= '0;
            col_reg_q <= '0;
            pat_reg_q <= '0;
        end else if (accept) begin
            third_q   <= start_third;
            name_q    <= start_name;
            line_q    <= start_line;
            col_reg_q <= col_reg;
            pat_reg_q <= pat_reg;
        end
    end

    tf_addr_gen #(
        .THIRD_W (THIRD_W),
        .NAME_W  (NAME_W),
        .LINE_W  (LINE_W)
    ) addr_i (
        .third    (third_q),
        .name     (name_q),
        .line     (line_q),
        .col_reg  (col_reg_q),
        .pat_reg  (pat_reg_q),
        .pat_addr (pat_addr),
        .col_addr (col_addr)
    );

    tf_fetch_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_valid   (start_valid),
        .start_ready   (start_ready),
        .accept        (accept),
        .pat_addr      (pat_addr),
        .col_addr      (col_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .pat_byte      (pat_byte),
        .col_byte      (col_byte),
        .done          (row_done)
    );

    tf_pixel_expand #(
        .NUM_PIX (NUM_PIX),
        .COLOR_W (COLOR_W)
    ) pix_i (
        .pat_byte (pat_byte),
        .col_byte (col_byte),
        .pixels   (row_pixels)
    );
endmodule

// File: rtl/tile_row_fetch_chk.sv
// Protocol checker for tile_row_fetch, attached with a bind.
// It tracks the low name and row bits of the accepted request on its own.
module tile_row_fetch_chk #(
    parameter int LINE_W = 3,
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_valid,
    input logic              start_ready,
    input logic [LINE_W-1:0] name_lo,
    input logic [LINE_W-1:0] start_line,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              row_done
);
    logic [2*LINE_W-1:0] exp_lo;

    // Remember the row offset of the accepted request
    always_ff @(posedge clk) begin
        if (!rst_n)                          exp_lo <= '0;
        else if (start_valid && start_ready) exp_lo <= {name_lo, start_line};
    end

    // R2: a request under back-pressure holds its valid and its address
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R3: the low address bits come from the accepted name and row
    a_r3_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2*LINE_W-1:0] == exp_lo));

    // R9: done lasts one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |=> !row_done);

    // R9: no new row is taken while a read is pending
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || row_done) |-> !start_ready);

    // R10: done only follows a response
    a_r10_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |-> $past(mem_rsp_valid));

    // R1: reset leaves the block idle
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!mem_req_valid && !row_done));
endmodule

bind tile_row_fetch tile_row_fetch_chk #(
    .LINE_W (LINE_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_valid   (start_valid),
    .start_ready   (start_ready),
    .name_lo       (start_name[LINE_W-1:0]),
    .start_line    (start_line),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .row_done      (row_done)
);

// File: tb/tile_row_fetch_tb_top.sv
// Sweep bench for tile_row_fetch. Drives and samples on the falling edge.
module tile_row_fetch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_valid;
    logic        start_ready;
    logic [1:0]  start_third;
    logic [7:0]  start_name;
    logic [2:0]  start_line;
    logic [7:0]  col_reg;
    logic [2:0]  pat_reg;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [13:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [7:0]  mem_rsp_data;
    logic        row_done;
    logic [31:0] row_pixels;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tile_row_fetch dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_valid   (start_valid),
        .start_ready   (start_ready),
        .start_third   (start_third),
        .start_name    (start_name),
        .start_line    (start_line),
        .col_reg       (col_reg),
        .pat_reg       (pat_reg),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .row_done      (row_done),
        .row_pixels    (row_pixels)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Memory contents as a function of address: different for each fetch kind
    function automatic logic [7:0] mem_of(input logic [13:0] a, input int ph);
        logic [7:0] v;
        v = a[7:0] ^ {a[13:8], 2'b01};
        if (ph == 1) v = (a[7:0] * 8'd37) ^ a[13:6];
        return v;
    endfunction

    task automatic run_row(input logic [1:0] th, input logic [7:0] nm, input logic [2:0] ln,
                           input logic [7:0] cr, input logic [2:0] pr, input int stall, input bit poke);
        logic [13:0] got [2];
        logic [7:0]  dat [2];
        logic [13:0] e_col, e_pat, e_off;
        logic [31:0] e_pix;
        e_col = {cr[7], cr[6:0] & {th, nm[7:3]}, nm[2:0], ln};
        e_pat = {pr[2], pr[1:0] & th, cr[4:0] & nm[7:3], nm[2:0], ln};
        e_off = 14'(8 * (nm % 8) + ln);
        start_valid = 1'b1; start_third = th; start_name = nm; start_line = ln;
        col_reg = cr; pat_reg = pr;
        chk(start_ready == 1'b1, "R9 idle ready", 32'(start_ready), 32'd1);
        @(posedge clk); @(negedge clk);
        start_valid = 1'b0;
        for (int ph = 0; ph < 2; ph++) begin
            for (int s = 0; s < stall; s++) begin
                got[ph] = mem_req_addr;
                if (poke && ph == 0) begin
                    start_valid = 1'b1; start_name = ~nm; start_line = ~ln;
                end
                chk(start_ready == 1'b0, "R9 busy", 32'(start_ready), 32'd0);
                @(posedge clk); @(negedge clk);
                chk(mem_req_valid && mem_req_addr == got[ph], "R2 hold", 32'(mem_req_addr), 32'(got[ph]));
            end
            start_valid = 1'b0;
            chk(mem_req_valid == 1'b1, "R2 request", 32'(mem_req_valid), 32'd1);
            got[ph] = mem_req_addr;
            mem_req_ready = 1'b1;
            @(posedge clk); @(negedge clk);
            mem_req_ready = 1'b0;
            chk(mem_req_valid == 1'b0, "R2 single request", 32'(mem_req_valid), 32'd0);
            dat[ph] = mem_of(got[ph], ph);
            mem_rsp_valid = 1'b1; mem_rsp_data = dat[ph];
            @(posedge clk); @(negedge clk);
            mem_rsp_valid = 1'b0; mem_rsp_data = 8'h00;
        end
        chk(got[0] == e_pat, "R4 pattern address", 32'(got[0]), 32'(e_pat));
        chk(got[1] == e_col, "R3 colour address", 32'(got[1]), 32'(e_col));
        if (cr == 8'h00) chk(got[1] == e_off, "R5 colour 0x00", 32'(got[1]), 32'(e_off));
        if (cr == 8'h80) chk(got[1] == 14'h2000 + e_off, "R5 colour 0x80", 32'(got[1]), 32'(14'h2000 + e_off));
        if (cr == 8'h9F) chk(got[1] == 14'(8192 + 8 * nm + ln), "R6 colour 0x9F", 32'(got[1]), 32'(8192 + 8 * nm + ln));
        if (cr[4:0] == 5'd0) begin
            e_pat = 14'(8192 * pr[2] + 2048 * (pr[1:0] & th) + 8 * (nm % 8) + ln);
            chk(got[0] == e_pat, "R7 shrunk pattern", 32'(got[0]), 32'(e_pat));
        end
        for (int i = 0; i < 8; i++)
            e_pix[4*i +: 4] = dat[0][7-i] ? dat[1][7:4] : dat[1][3:0];
        chk(row_done == 1'b1, "R9 done", 32'(row_done), 32'd1);
        chk(row_pixels == e_pix, "R8 pixels", row_pixels, e_pix);
        @(posedge clk); @(negedge clk);
        chk(row_done == 1'b0, "R9 done one cycle", 32'(row_done), 32'd0);
        chk(start_ready == 1'b1, "R9 ready again", 32'(start_ready), 32'd1);
    endtask

    task automatic idle_rsp_poke();
        mem_rsp_valid = 1'b1; mem_rsp_data = 8'hFF;
        @(posedge clk); @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = 8'h00;
        @(posedge clk); @(negedge clk);
        chk(!row_done && !mem_req_valid && start_ready, "R10 stray response",
            {29'd0, row_done, mem_req_valid, start_ready}, 32'd1);
    endtask

    initial begin
        logic [7:0] crs [4] = '{8'h00, 8'h80, 8'h9F, 8'hFF};
        rst_n = 1'b0; start_valid = 1'b0; start_third = '0; start_name = '0; start_line = '0;
        col_reg = '0; pat_reg = '0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        repeat (4) @(negedge clk);
        chk(start_ready && !mem_req_valid && !row_done, "R1 in reset",
            {29'd0, start_ready, mem_req_valid, row_done}, 32'd4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(start_ready && !mem_req_valid && !row_done, "R1 after reset",
            {29'd0, start_ready, mem_req_valid, row_done}, 32'd4);
        idle_rsp_poke();
        for (int ci = 0; ci < 4; ci++)
            for (int th = 0; th < 3; th++)
                for (int nm = 0; nm < 256; nm++)
                    run_row(2'(th), 8'(nm), 3'(nm + th), crs[ci], 3'((nm >> 2) ^ th),
                            (nm + ci) % 3, (nm % 17) == 1);
        idle_rsp_poke();
        run_row(2'd2, 8'hA5, 3'd6, 8'h1F, 3'd3, 2, 1'b1);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule